// File: doc/BRIEF.md
# Scaled-Counter PWM Timer

This block is a pulse-width timer with one wide free-running counter and four compare channels. A 4-bit scale value selects a window of the wide counter as a narrower scaled count. Each channel compares its own register against that scaled count. The prescale is therefore a choice of which counter bits to look at, not a separate clock divider. Channel 0 sets the period: with restart-on-match enabled, the counter returns to zero at the point where the scaled count would reach the channel 0 value. Channels 1 to 3 drive the waveform outputs.

Software controls the block through a simple 32-bit register bus with a write strobe and a combinational read. The counter can run continuously or for a single period. In single-period mode, hardware clears the single-period enable when the period ends. Bits for center alignment, ganging, deglitch and sticky behaviour are stored and read back but have no effect on the waveforms.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero except the compare-flag bits 31:28 of the control word (0x00). Because every compare value is zero, those flag bits and `pwm_o` are all ones after reset, and the counter holds at zero.
- R2: The counter (0x08) advances by exactly one per clock while control bit 12 (continuous run) or bit 13 (single period) is set. It holds its value while both bits are clear.
- R3: The scaled count (0x10) is the counter shifted right by control bits 3:0, keeping the low 16 bits. Writes to 0x10 have no effect.
- R4: When control bit 9 (restart-on-match) is set and the counter is running, a clock edge at which the scaled value of the counter plus one would equal compare register 0 loads zero into the counter. With scale s and compare 0 value P, the period is P·2^s clocks. `match_o[0]` is high during the last clock of each period.
- R5: With bit 9 and bit 13 clear, the 31-bit counter wraps from its all-ones value to zero.
- R6: `pwm_o[n]`, and control bit 28+n, are high while the scaled count is greater than or equal to compare register n (0x20 + 4n).
- R7: A channel whose compare value is zero stays high for the whole period. A channel whose compare value equals the channel 0 period value stays low for the whole period.
- R8: In single-period mode the counter runs from zero to the end of one period, returns to zero, and clears bit 13. With bit 12 clear it then stops.
- R9: A write to 0x08 loads the counter with the write data (low 31 bits). This write takes priority over the increment and over the restart in the same cycle.
- R10: Control bits 3:0, 8, 9, 10, 12, 13, 19:16 and 24:27 are writable and read back as written. Bits 31:28 cannot be written, and all other bits read zero.
- R11: For n = 1..3, `match_o[n]` is high while the scaled count equals compare register n.
- R12: Compare registers hold 16 bits. Their upper read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| match_o | output | 4 | Channel 0: end-of-period; channels 1..3: scaled count equals compare |
| pwm_o | output | 4 | Scaled count at or above each channel's compare value |

## Verification
A register write lands on the clock edge that samples the strobe, and reads are combinational. A written value is therefore visible half a cycle later, while a changed run enable first moves the counter one edge after the write. All outputs are combinational views of registered state, so they change in the same cycle as the count that causes them. `match_o[0]` rises in the cycle before the counter reads zero. A behavioural model advances on each rising edge from the same bus inputs. Every output and the read data are compared against it two nanoseconds after each falling edge, when inputs and state are both settled. The directed checks count samples over whole periods starting from a known zero count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NUM_CH  = 4;
    localparam int IDX_W   = $clog2(NUM_CH);
    localparam int SCALE_W = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SCALED = 8'h10;
    localparam logic [3:0]        CMP_PAGE   = 4'h2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_COUNT,
        SEL_SCALED,
        SEL_CMP
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_CH-1:0]  gang;
        logic [NUM_CH-1:0]  center;
        logic               run_once;
        logic               run_always;
        logic               deglitch;
        logic               zero_cmp;
        logic               sticky;
        logic [SCALE_W-1:0] scale;
    } pwm_ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00)            s = SEL_NONE;
        else if (a == OFF_CTRL)         s = SEL_CTRL;
        else if (a == OFF_COUNT)        s = SEL_COUNT;
        else if (a == OFF_SCALED)       s = SEL_SCALED;
        else if (a[7:4] == CMP_PAGE)    s = SEL_CMP;
        else                            s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input pwm_ctrl_t c,
                                                    input logic [NUM_CH-1:0] flags);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[3:0]   = c.scale;
        w[8]     = c.sticky;
        w[9]     = c.zero_cmp;
        w[10]    = c.deglitch;
        w[12]    = c.run_always;
        w[13]    = c.run_once;
        w[19:16] = c.center;
        w[27:24] = c.gang;
        w[31:28] = flags;
        return w;
    endfunction

    function automatic pwm_ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        pwm_ctrl_t c;
        c.scale      = w[3:0];
        c.sticky     = w[8];
        c.zero_cmp   = w[9];
        c.deglitch   = w[10];
        c.run_always = w[12];
        c.run_once   = w[13];
        c.center     = w[19:16];
        c.gang       = w[27:24];
        return c;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int CNT_W = CMP_W + 15
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wen,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         once_done,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [CMP_W-1:0]             scaled,
    input  logic [NUM_CH-1:0]            flags,
    output pwm_ctrl_t                    ctrl,
    output logic [NUM_CH-1:0][CMP_W-1:0] cmp,
    output logic                         cnt_load,
    output logic [DATA_W-1:0]            rdata
);

    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;

    assign sel      = decode_addr(addr);
    assign idx      = addr[IDX_W+1:2];
    assign cnt_load = wen && (sel == SEL_COUNT);

    // Control word: software write wins over the hardware single-period clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wen && sel == SEL_CTRL) begin
            ctrl <= ctrl_unpack(wdata);
        end else if (once_done) begin
            ctrl.run_once <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[g] <= '0;
            end else if (wen && sel == SEL_CMP && idx == IDX_W'(g)) begin
                cmp[g] <= wdata[CMP_W-1:0];
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:   rdata = ctrl_pack(ctrl, flags);
            SEL_COUNT:  rdata = DATA_W'(cnt);
            SEL_SCALED: rdata = DATA_W'(scaled);
            SEL_CMP:    rdata = DATA_W'(cmp[idx]);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int CNT_W = CMP_W + 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SCALE_W-1:0] scale,
    input  logic               run_en,
    input  logic               restart_en,
    input  logic [CMP_W-1:0]   period,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CMP_W-1:0]   scaled,
    output logic               wrap
);

    logic [CNT_W-1:0] cnt_inc;
    logic [CMP_W-1:0] scaled_inc;

    assign cnt_inc    = cnt_q + CNT_W'(1);
    // Window of CMP_W bits starting at the scale position; CNT_W leaves room for the largest shift
    assign scaled     = cnt_q[scale +: CMP_W];
    assign scaled_inc = cnt_inc[scale +: CMP_W];
    assign wrap       = run_en && restart_en && (scaled_inc == period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (run_en) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CMP_W = 16
) (
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp_val,
    output logic             at_or_above,
    output logic             equal
);

    assign at_or_above = (scaled >= cmp_val);
    assign equal       = (scaled == cmp_val);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int CMP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wen,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CH-1:0]    match_o,
    output logic [NUM_CH-1:0]    pwm_o
);

    localparam int CNT_W = CMP_W + 15;

    pwm_ctrl_t                    ctrl;
    logic [NUM_CH-1:0][CMP_W-1:0] cmp;
    logic                         cnt_load;
    logic [CNT_W-1:0]             cnt;
    logic [CMP_W-1:0]             scaled;
    logic                         wrap;
    logic                         run_en;
    logic                         once_done;
    logic [NUM_CH-1:0]            above;
    logic [NUM_CH-1:0]            equal;

    assign run_en    = ctrl.run_always | ctrl.run_once;
    assign once_done = wrap & ctrl.run_once;

    pwm_regs #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wen       (bus_wen),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .once_done (once_done),
        .cnt       (cnt),
        .scaled    (scaled),
        .flags     (above),
        .ctrl      (ctrl),
        .cmp       (cmp),
        .cnt_load  (cnt_load),
        .rdata     (bus_rdata)
    );

    pwm_counter #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .scale      (ctrl.scale),
        .run_en     (run_en),
        .restart_en (ctrl.zero_cmp | ctrl.run_once),
        .period     (cmp[0]),
        .load       (cnt_load),
        .load_val   (CNT_W'(bus_wdata)),
        .cnt_q      (cnt),
        .scaled     (scaled),
        .wrap       (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.CMP_W(CMP_W)) u_ch (
            .scaled      (scaled),
            .cmp_val     (cmp[g]),
            .at_or_above (above[g]),
            .equal       (equal[g])
        );
        if (g == 0) begin : g_period
            assign match_o[g] = wrap;
        end else begin : g_duty
            assign match_o[g] = equal[g];
        end
    end

    assign pwm_o = above;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int CNT_W = CMP_W + 15
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_wen,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [CNT_W-1:0]             cnt,
    input logic                         wrap,
    input logic                         run_en,
    input logic                         run_once,
    input logic [NUM_CH-1:0][CMP_W-1:0] cmp,
    input logic [NUM_CH-1:0]            pwm_o
);

    logic cnt_wr;
    logic ctrl_wr;
    assign cnt_wr  = bus_wen && (bus_addr == OFF_COUNT);
    assign ctrl_wr = bus_wen && (bus_addr == OFF_CTRL);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_wr) |=> $stable(cnt)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_en && !wrap && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run_en && !wrap && !cnt_wr && (&cnt)) |=> (cnt == '0)); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wrap && !cnt_wr) |=> (cnt == '0)); // R4

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(CNT_W'(bus_wdata)))); // R9

    AST_ONCE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wrap && run_once && !ctrl_wr) |=> !run_once); // R8

    for (genvar g = 1; g < NUM_CH; g++) begin : g_zero
        AST_CMP_ZERO_HIGH: assert property (@(posedge clk) disable iff (rst)
            (cmp[g] == '0) |-> pwm_o[g]); // R7
    end

endmodule

bind pwm_timer pwm_timer_chk #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .wrap      (wrap),
    .run_en    (run_en),
    .run_once  (ctrl.run_once),
    .cmp       (cmp),
    .pwm_o     (pwm_o)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;

    localparam longint unsigned CNT_MASK = 64'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h3C;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  match_o;
    logic [3:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    bit live   = 1'b0;

    always #5 clk = ~clk;

    pwm_timer u0 (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .match_o(match_o), .pwm_o(pwm_o)
    );

    // ---------------- behavioural reference ----------------
    int unsigned     m_cfg;
    longint unsigned m_cnt;
    int unsigned     m_cmp [4];

    function automatic int unsigned m_scaled(input longint unsigned c);
        return int'((c >> (m_cfg & 32'hF)) & 64'hFFFF);
    endfunction

    function automatic bit m_running();
        return m_cfg[12] || m_cfg[13];
    endfunction

    function automatic bit m_wrap();
        longint unsigned n = (m_cnt + 1) & CNT_MASK;
        return m_running() && (m_cfg[9] || m_cfg[13]) && (m_scaled(n) == m_cmp[0]);
    endfunction

    function automatic logic [3:0] m_pwm();
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (m_scaled(m_cnt) >= m_cmp[i]);
        return p;
    endfunction

    function automatic logic [3:0] m_match();
        logic [3:0] m;
        m[0] = m_wrap();
        for (int i = 1; i < 4; i++) m[i] = (m_scaled(m_cnt) == m_cmp[i]);
        return m;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return m_cfg | ({28'd0, m_pwm()} << 28);
        if (a == 8'h08) return 32'(m_cnt);
        if (a == 8'h10) return m_scaled(m_cnt);
        if (a[7:4] == 4'h2 && a[1:0] == 2'b00) return m_cmp[a[3:2]];
        return 32'h0;
    endfunction

    always @(posedge clk) begin : model
        bit w;
        if (rst) begin
            m_cfg = 0; m_cnt = 0;
            for (int i = 0; i < 4; i++) m_cmp[i] = 0;
        end else begin
            w = m_wrap();
            if (bus_wen && bus_addr == 8'h08) m_cnt = bus_wdata & CNT_MASK;
            else if (w)                      m_cnt = 0;
            else if (m_running())            m_cnt = (m_cnt + 1) & CNT_MASK;
            if (bus_wen && bus_addr == 8'h00) m_cfg = bus_wdata & 32'h0F0F_370F;
            else if (w && m_cfg[13])          m_cfg = m_cfg & ~32'h2000;
            if (bus_wen && bus_addr[7:4] == 4'h2 && bus_addr[1:0] == 2'b00)
                m_cmp[bus_addr[3:2]] = bus_wdata & 32'hFFFF;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every cycle: outputs and read data against the model
    always @(negedge clk) begin
        if (live) begin
            #2;
            chk("R6 pwm_o vs model", 32'(pwm_o), 32'(m_pwm()));
            chk("R11/R4 match_o vs model", 32'(match_o), 32'(m_match()));
            chk("R3/R10/R12 read data vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 8'h3C;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    // Stop the counter, zero it and load the period and compare values
    task automatic setup(input int unsigned c0, input int unsigned c1,
                         input int unsigned c2, input int unsigned c3);
        wr(8'h00, 32'h0);
        wr(8'h20, c0); wr(8'h24, c1); wr(8'h28, c2); wr(8'h2C, c3);
        wr(8'h08, 32'h0);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        int hi1, hi2, hi3, m0, m1, mx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R1: reset state
        rd(8'h00, d); chk("R1 control after reset", d, 32'hF000_0000);
        rd(8'h08, d); chk("R1 counter after reset", d, 32'h0);
        rd(8'h20, d); chk("R1 compare 0 after reset", d, 32'h0);
        chk("R1 pwm_o after reset", 32'(pwm_o), 32'hF);

        // R9 / R2: load while stopped, hold, then run
        wr(8'h08, 32'd100);
        repeat (3) @(posedge clk);
        rd(8'h08, d); chk("R2 counter holds while stopped", d, 32'd100);
        wr(8'h00, 32'h1000);
        rd(8'h08, d); chk("R2 counter steps by one", d, 32'd101);
        wr(8'h08, 32'h1234);
        rd(8'h08, d); chk("R9 load wins over increment", d, 32'h1235);

        // R3: scaled view and ignored write
        wr(8'h00, 32'h4);
        wr(8'h08, 32'h12345);
        wr(8'h10, 32'h0);
        rd(8'h10, d); chk("R3 scaled count", d, 32'h1234);
        rd(8'h08, d); chk("R3 counter untouched by scaled write", d, 32'h12345);

        // R12: compare width
        wr(8'h24, 32'hABCD_1234);
        rd(8'h24, d); chk("R12 compare upper bits zero", d, 32'h1234);

        // R10: writable control bits
        wr(8'h20, 32'hFFFF);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R10 control readback", d & 32'h0FFF_FFFF, 32'h0F0F_370F);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R10 control cleared", d & 32'h0FFF_FFFF, 32'h0);

        // R4 / R6 / R7 / R11: period 5, scale 0
        setup(5, 2, 0, 5);
        wr(8'h00, 32'h1200);
        hi1 = 0; hi2 = 0; hi3 = 0; m0 = 0; m1 = 0; mx = 0;
        for (int i = 0; i < 10; i++) begin
            #2;
            hi1 += pwm_o[1]; hi2 += pwm_o[2]; hi3 += pwm_o[3];
            m0 += match_o[0]; m1 += match_o[1];
            if (32'(m_cnt) > 0) begin end
            if (int'(u0.bus_rdata) < 0) begin end
            @(negedge clk);
        end
        chk("R6 channel 1 high cycles", hi1, 6);
        chk("R7 zero compare always high", hi2, 10);
        chk("R7 compare equal period always low", hi3, 0);
        chk("R4 end-of-period pulses", m0, 2);
        chk("R11 channel 1 equal pulses", m1, 2);

        // R4: period with scale 2, compare 0 = 3 gives 12 clocks
        setup(3, 1, 1, 1);
        wr(8'h00, 32'h1202);
        m0 = 0; mx = 0;
        bus_addr = 8'h08;
        for (int i = 0; i < 24; i++) begin
            #2;
            m0 += match_o[0];
            if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
            @(negedge clk);
        end
        chk("R4 scaled period pulses", m0, 2);
        chk("R4 scaled period top count", mx, 11);

        // R8: single period of 4 clocks
        setup(4, 1, 2, 3);
        wr(8'h00, 32'h2000);
        mx = 0;
        bus_addr = 8'h08;
        for (int i = 0; i < 10; i++) begin
            #2;
            if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
            @(negedge clk);
        end
        chk("R8 single period top count", mx, 3);
        rd(8'h08, d); chk("R8 counter stopped at zero", d, 32'h0);
        rd(8'h00, d); chk("R8 single-period bit cleared", d & 32'h3000, 32'h0);

        // R5: free wrap at counter width
        wr(8'h00, 32'h1000);
        wr(8'h08, 32'h7FFF_FFFE);
        rd(8'h08, d); chk("R5 counter before wrap", d, 32'h7FFF_FFFF);
        rd(8'h08, d); chk("R5 counter wraps to zero", d, 32'h0);

        wr(8'h00, 32'h0);
        live = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule